// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the software-facing programming port of a single eight-line interrupt controller stage. Software drives it through two addresses. Port 0 takes the word that starts initialization, the status-control word and the command word. Port 1 takes the rest of the initialization words and, outside initialization, the request mask. A small sequencer tracks where the initialization stands. After the start word, port 1 expects the vector base, then a word that is consumed and ignored, then an optional mode word. The start word chooses whether the mode word is expected.

The port holds the in-service register, the rotation base that sets line priority, and all mode flags. It applies specific and non-specific end-of-interrupt commands, with or without a priority rotation, and rotation-only commands. A private priority finder, rotated by the current base, picks the line that a non-specific end-of-interrupt retires. A second finder serves poll reads. The acknowledge logic next to this block marks lines as entering service through a set vector. The latched request vector comes in from the request stage. Reads are registered and return data one cycle after the strobe.

Top module: `pic_cmd_port`

## Requirements
- R1: After reset, mask, in-service, rotation base, vector base, every mode flag, the error flag, the drop pulse, the poll clear vector and read data are all zero.
- R2: A port 0 write with bit 4 set clears mask, in-service, rotation base, vector base and all flags, and takes the fourth-word flag from bit 0. It pulses `irq_drop_o` for the one following cycle and sets `init_err_o` to (bit 1 OR bit 3) of that word.
- R3: After the start word, port 1 writes load the vector base (data AND 0xF8), then consume one word, then load nested mode from bit 4 and auto-EOI from bit 1 only if the fourth-word flag was set; otherwise the sequence returns to idle. Only an idle port 1 write loads the mask.
- R4: A port 0 write with bit 4 clear and bit 3 set is a status word. Bit 2 sets poll. When bit 1 is set, read-select takes bit 0. When bit 6 is set, special mask takes bit 5.
- R5: For any other port 0 write, bits 7:5 are a command code. Codes 0 and 4 set rotate-on-auto-EOI to bit 7 of the word.
- R6: Code 1 clears the in-service bit of highest priority. Priority runs from the rotation base upward, modulo 8. With an empty in-service register, code 1 and code 5 change nothing.
- R7: Code 5 acts like code 1 and also sets the rotation base to the retired line plus 1, modulo 8.
- R8: Code 3 clears the in-service bit named by bits 2:0. Code 7 does the same and sets the rotation base to that line plus 1. Code 6 only sets the rotation base to bits 2:0 plus 1, modulo 8. Code 2 has no effect.
- R9: Reads return data on `rdata_o` one cycle after `rd_en_i`. Without poll, port 1 gives the mask and port 0 gives in-service when read-select is 1 or the request vector when it is 0.
- R10: A read with poll set, at either address, clears poll. It returns the number of the highest-priority unmasked request in bits 2:0, upper bits zero, if that request outranks every in-service line. In that case it also clears that line's in-service bit and pulses the line's one-hot bit on `poll_clr_o` for one cycle. Otherwise it returns 7.
- R11: `svc_set_i` bits are set in the in-service register in the same cycle. A set wins over an end-of-interrupt clear of the same line in that cycle, and a start word wins over both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 1 | Port select |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| irr_i | input | 8 | Latched request vector from the request stage |
| svc_set_i | input | 8 | Lines entering service, from acknowledge logic |
| rdata_o | output | 8 | Registered read data |
| mask_o | output | 8 | Request mask |
| isr_o | output | 8 | In-service register |
| vbase_o | output | 8 | Vector base, low three bits zero |
| rot_base_o | output | 3 | Line holding top priority |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt mode |
| nested_o | output | 1 | Special nested mode |
| rot_aeoi_o | output | 1 | Rotate on automatic end-of-interrupt |
| smask_o | output | 1 | Special mask mode |
| init_err_o | output | 1 | Last start word asked for an unsupported mode |
| irq_drop_o | output | 1 | One-cycle pulse: drop the interrupt output |
| poll_clr_o | output | 8 | One-hot request clear from a winning poll read |

## Verification
The in-service register has three writers that can act in one cycle: the acknowledge set vector, an end-of-interrupt clear, and a start word. The bench issues a specific end-of-interrupt for line 4 while the set vector marks line 4, and expects the bit to stay set. It also issues a start word while the set vector marks every line, and expects an empty register afterwards. A poll read that retires a line is checked against its return value, the one-hot clear pulse and the in-service bits that are left.

// File: rtl/pic_port_pkg.sv
package pic_port_pkg;

  // Initialization progress
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_SKIP = 2'd2,
    SEQ_MODE = 2'd3
  } seq_e;

  // Command word field bits 7:5
  typedef enum logic [2:0] {
    CMD_RAEOI_OFF = 3'd0,
    CMD_NS_EOI    = 3'd1,
    CMD_NOP       = 3'd2,
    CMD_SP_EOI    = 3'd3,
    CMD_RAEOI_ON  = 3'd4,
    CMD_NS_ROT    = 3'd5,
    CMD_SET_PRI   = 3'd6,
    CMD_SP_ROT    = 3'd7
  } cmd_e;

endpackage

// File: rtl/pic_prio_rank.sv
module pic_prio_rank #(
  parameter int N_LINES = 8,
  localparam int IW = $clog2(N_LINES),
  localparam int RW = IW + 1
) (
  input  logic [N_LINES-1:0] vec_i,
  input  logic [IW-1:0]      base_i,
  output logic               hit_o,
  output logic [RW-1:0]      rank_o,
  output logic [IW-1:0]      line_o
);

  // Scan from lowest priority to highest so the last hit wins.
  always_comb begin
    hit_o  = 1'b0;
    rank_o = RW'(N_LINES);
    line_o = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (vec_i[base_i + IW'(i)]) begin
        hit_o  = 1'b1;
        rank_o = RW'(i);
        line_o = base_i + IW'(i);
      end
    end
  end

endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic need4_i,
  input  logic step_i,
  output seq_e stage_o
);

  seq_e stage_q, stage_n;
  logic need4_q, need4_n;

  always_comb begin
    stage_n = stage_q;
    need4_n = need4_q;
    if (start_i) begin
      stage_n = SEQ_BASE;
      need4_n = need4_i;
    end else if (step_i) begin
      case (stage_q)
        SEQ_BASE: stage_n = SEQ_SKIP;
        SEQ_SKIP: stage_n = need4_q ? SEQ_MODE : SEQ_IDLE;
        SEQ_MODE: stage_n = SEQ_IDLE;
        default:  stage_n = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= SEQ_IDLE;
      need4_q <= 1'b0;
    end else begin
      stage_q <= stage_n;
      need4_q <= need4_n;
    end
  end

  assign stage_o = stage_q;

  // R3
  skip_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !start_i && stage_q == SEQ_SKIP && !need4_q) |=> stage_q == SEQ_IDLE);

  // R3
  mode_needs4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == SEQ_MODE) |-> need4_q);

endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
  import pic_port_pkg::*;
#(
  parameter int N_LINES = 8,
  localparam int IW = $clog2(N_LINES),
  localparam int RW = IW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [N_LINES-1:0] irr_i,
  input  logic [N_LINES-1:0] svc_set_i,
  output logic [7:0]         rdata_o,
  output logic [N_LINES-1:0] mask_o,
  output logic [N_LINES-1:0] isr_o,
  output logic [7:0]         vbase_o,
  output logic [IW-1:0]      rot_base_o,
  output logic               auto_eoi_o,
  output logic               nested_o,
  output logic               rot_aeoi_o,
  output logic               smask_o,
  output logic               init_err_o,
  output logic               irq_drop_o,
  output logic [N_LINES-1:0] poll_clr_o
);

  localparam logic [N_LINES-1:0] ONE = N_LINES'(1);
  localparam logic [7:0]         VB_KEEP = ~8'(N_LINES - 1);

  // State
  logic [N_LINES-1:0] mask_q, mask_n, isr_q, isr_n, pclr_q, pclr_n;
  logic [7:0]         vbase_q, vbase_n, rdata_q, rdata_n;
  logic [IW-1:0]      rot_q, rot_n;
  logic aeoi_q, aeoi_n, nest_q, nest_n, raeoi_q, raeoi_n;
  logic rsel_q, rsel_n, poll_q, poll_n, smask_q, smask_n;
  logic err_q, err_n, drop_q, drop_n;

  // Decode
  logic wr0, wr1, is_init, is_stat, is_cmd, poll_rd;
  cmd_e cmd;
  logic [IW-1:0] lnum;
  seq_e stage;

  assign wr0     = wr_en_i && !addr_i;
  assign wr1     = wr_en_i &&  addr_i;
  assign is_init = wr0 &&  wdata_i[4];
  assign is_stat = wr0 && !wdata_i[4] &&  wdata_i[3];
  assign is_cmd  = wr0 && !wdata_i[4] && !wdata_i[3];
  assign cmd     = cmd_e'(wdata_i[7:5]);
  assign lnum    = wdata_i[IW-1:0];
  assign poll_rd = rd_en_i && poll_q;

  // Priority finders
  logic          isr_hit, req_hit, poll_win;
  logic [RW-1:0] isr_rank, req_rank;
  logic [IW-1:0] isr_line, req_line;

  pic_prio_rank #(.N_LINES(N_LINES)) u_isr_rank (
    .vec_i (isr_q),
    .base_i(rot_q),
    .hit_o (isr_hit),
    .rank_o(isr_rank),
    .line_o(isr_line)
  );

  pic_prio_rank #(.N_LINES(N_LINES)) u_req_rank (
    .vec_i (irr_i & ~mask_q),
    .base_i(rot_q),
    .hit_o (req_hit),
    .rank_o(req_rank),
    .line_o(req_line)
  );

  assign poll_win = req_hit && (req_rank < isr_rank);

  pic_init_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(is_init),
    .need4_i(wdata_i[0]),
    .step_i (wr1),
    .stage_o(stage)
  );

  // Next state
  logic [N_LINES-1:0] isr_clr;

  always_comb begin
    mask_n  = mask_q;
    vbase_n = vbase_q;
    rot_n   = rot_q;
    aeoi_n  = aeoi_q;
    nest_n  = nest_q;
    raeoi_n = raeoi_q;
    rsel_n  = rsel_q;
    poll_n  = poll_q;
    smask_n = smask_q;
    err_n   = err_q;
    drop_n  = 1'b0;
    pclr_n  = '0;
    isr_clr = '0;

    if (poll_rd) begin
      poll_n = 1'b0;
      if (poll_win) begin
        isr_clr = ONE << req_line;
        pclr_n  = ONE << req_line;
      end
    end

    if (is_stat) begin
      if (wdata_i[2]) poll_n  = 1'b1;
      if (wdata_i[1]) rsel_n  = wdata_i[0];
      if (wdata_i[6]) smask_n = wdata_i[5];
    end

    if (is_cmd) begin
      case (cmd)
        CMD_RAEOI_OFF, CMD_RAEOI_ON: raeoi_n = wdata_i[7];
        CMD_NS_EOI, CMD_NS_ROT: begin
          if (isr_hit) begin
            isr_clr = isr_clr | (ONE << isr_line);
            if (cmd == CMD_NS_ROT) rot_n = isr_line + IW'(1);
          end
        end
        CMD_SP_EOI: isr_clr = isr_clr | (ONE << lnum);
        CMD_SET_PRI: rot_n = lnum + IW'(1);
        CMD_SP_ROT: begin
          isr_clr = isr_clr | (ONE << lnum);
          rot_n   = lnum + IW'(1);
        end
        default: ;
      endcase
    end

    isr_n = (isr_q & ~isr_clr) | svc_set_i;

    if (wr1) begin
      case (stage)
        SEQ_IDLE: mask_n  = wdata_i[N_LINES-1:0];
        SEQ_BASE: vbase_n = wdata_i & VB_KEEP;
        SEQ_MODE: begin
          nest_n = wdata_i[4];
          aeoi_n = wdata_i[1];
        end
        default: ;
      endcase
    end

    if (is_init) begin
      mask_n  = '0;
      isr_n   = '0;
      vbase_n = '0;
      rot_n   = '0;
      aeoi_n  = 1'b0;
      nest_n  = 1'b0;
      raeoi_n = 1'b0;
      rsel_n  = 1'b0;
      poll_n  = 1'b0;
      smask_n = 1'b0;
      err_n   = wdata_i[1] | wdata_i[3];
      drop_n  = 1'b1;
    end
  end

  // Read data
  always_comb begin
    if (poll_q)
      rdata_n = poll_win ? 8'(req_line) : 8'(N_LINES - 1);
    else if (addr_i)
      rdata_n = 8'(mask_q);
    else if (rsel_q)
      rdata_n = 8'(isr_q);
    else
      rdata_n = 8'(irr_i);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      isr_q   <= '0;
      vbase_q <= '0;
      rot_q   <= '0;
      aeoi_q  <= 1'b0;
      nest_q  <= 1'b0;
      raeoi_q <= 1'b0;
      rsel_q  <= 1'b0;
      poll_q  <= 1'b0;
      smask_q <= 1'b0;
      err_q   <= 1'b0;
      drop_q  <= 1'b0;
      pclr_q  <= '0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_n;
      isr_q   <= isr_n;
      vbase_q <= vbase_n;
      rot_q   <= rot_n;
      aeoi_q  <= aeoi_n;
      nest_q  <= nest_n;
      raeoi_q <= raeoi_n;
      rsel_q  <= rsel_n;
      poll_q  <= poll_n;
      smask_q <= smask_n;
      err_q   <= err_n;
      drop_q  <= drop_n;
      pclr_q  <= pclr_n;
      if (rd_en_i) rdata_q <= rdata_n;
    end
  end

  assign rdata_o    = rdata_q;
  assign mask_o     = mask_q;
  assign isr_o      = isr_q;
  assign vbase_o    = vbase_q;
  assign rot_base_o = rot_q;
  assign auto_eoi_o = aeoi_q;
  assign nested_o   = nest_q;
  assign rot_aeoi_o = raeoi_q;
  assign smask_o    = smask_q;
  assign init_err_o = err_q;
  assign irq_drop_o = drop_q;
  assign poll_clr_o = pclr_q;

  // R2
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_init |=> (isr_q == '0 && mask_q == '0 && rot_q == '0 && !poll_q));

  // R6
  empty_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && (cmd == CMD_NS_EOI || cmd == CMD_NS_ROT) && isr_q == '0 &&
     svc_set_i == '0) |=> (isr_q == '0 && $stable(rot_q)));

  // R9
  mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i && !poll_q) |=> rdata_q == $past(mask_q));

  // R10
  poll_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd && !is_stat) |=> !poll_q);

  // R10
  poll_clr_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pclr_q));

  // R11
  svc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_set_i != '0 && !is_init) |=> ((isr_q & $past(svc_set_i)) == $past(svc_set_i)));

endmodule

// File: tb/sim_pic_cmd_port.sv
`timescale 1ns/1ps
module sim_pic_cmd_port;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       addr;
  logic [7:0] wdata;
  logic       wr_en, rd_en;
  logic [7:0] irr, svc_set;
  logic [7:0] rdata, mask, isr, vbase, pclr;
  logic [2:0] rot_base;
  logic       aeoi, nested, raeoi, smask, ierr, drop;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pic_cmd_port u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .irr_i(irr), .svc_set_i(svc_set),
    .rdata_o(rdata), .mask_o(mask), .isr_o(isr), .vbase_o(vbase),
    .rot_base_o(rot_base), .auto_eoi_o(aeoi), .nested_o(nested),
    .rot_aeoi_o(raeoi), .smask_o(smask), .init_err_o(ierr),
    .irq_drop_o(drop), .poll_clr_o(pclr)
  );

  // Entry: op[22:21] (0 write, 1 read+check, 2 svc pulse, 3 set irr),
  // addr[20], data[19:12], expected[11:4], requirement[3:0]
  localparam int NV = 35;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 1'b0, 8'h11, 8'h00, 4'd3},  // start, fourth word wanted
    {2'd0, 1'b1, 8'h47, 8'h00, 4'd3},  // vector base 0x40
    {2'd0, 1'b1, 8'h00, 8'h00, 4'd3},  // consumed word
    {2'd0, 1'b1, 8'h12, 8'h00, 4'd3},  // nested + auto-EOI
    {2'd0, 1'b1, 8'hA5, 8'h00, 4'd3},  // mask
    {2'd1, 1'b1, 8'h00, 8'hA5, 4'd3},  // R3 mask readback
    {2'd3, 1'b0, 8'h5A, 8'h00, 4'd9},
    {2'd1, 1'b0, 8'h00, 8'h5A, 4'd9},  // R9 request vector
    {2'd0, 1'b0, 8'h0B, 8'h00, 4'd4},  // read-select := 1
    {2'd2, 1'b0, 8'h28, 8'h00, 4'd11},
    {2'd1, 1'b0, 8'h00, 8'h28, 4'd4},  // R4 in-service visible
    {2'd0, 1'b0, 8'h20, 8'h00, 4'd6},  // code 1, base 0 -> line 3
    {2'd1, 1'b0, 8'h00, 8'h20, 4'd6},  // R6
    {2'd2, 1'b0, 8'h81, 8'h00, 4'd11},
    {2'd0, 1'b0, 8'hA0, 8'h00, 4'd7},  // code 5 -> line 0, base 1
    {2'd1, 1'b0, 8'h00, 8'hA0, 4'd7},  // R7
    {2'd0, 1'b0, 8'h67, 8'h00, 4'd8},  // code 3 line 7
    {2'd1, 1'b0, 8'h00, 8'h20, 4'd8},  // R8
    {2'd0, 1'b0, 8'hC3, 8'h00, 4'd8},  // code 6 -> base 4
    {2'd2, 1'b0, 8'h0C, 8'h00, 4'd11},
    {2'd0, 1'b0, 8'h20, 8'h00, 4'd6},  // code 1 base 4 -> line 5
    {2'd1, 1'b0, 8'h00, 8'h0C, 4'd6},  // R6 rotated order
    {2'd0, 1'b0, 8'hE2, 8'h00, 4'd8},  // code 7 line 2 -> base 3
    {2'd1, 1'b0, 8'h00, 8'h08, 4'd8},  // R8
    {2'd0, 1'b0, 8'h40, 8'h00, 4'd8},  // code 2
    {2'd1, 1'b0, 8'h00, 8'h08, 4'd8},  // R8 no effect
    {2'd0, 1'b0, 8'h80, 8'h00, 4'd5},  // code 4
    {2'd0, 1'b0, 8'h0C, 8'h00, 4'd10}, // poll
    {2'd1, 1'b1, 8'h00, 8'h07, 4'd10}, // R10 line 3 already in service
    {2'd1, 1'b1, 8'h00, 8'hA5, 4'd10}, // poll cleared, mask again
    {2'd0, 1'b0, 8'h20, 8'h00, 4'd6},  // retire line 3
    {2'd0, 1'b0, 8'h0C, 8'h00, 4'd10},
    {2'd1, 1'b0, 8'h00, 8'h03, 4'd10}, // R10 winner line 3
    {2'd1, 1'b0, 8'h00, 8'h00, 4'd9},
    {2'd0, 1'b0, 8'h68, 8'h00, 4'd4}   // special mask on
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic svc(input logic [7:0] v);
    @(negedge clk);
    svc_set = v;
    @(negedge clk);
    svc_set = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = 1'b0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    irr = '0; svc_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 mask", mask, 8'h00);
    chk("R1 isr", isr, 8'h00);
    chk("R1 vbase", vbase, 8'h00);
    chk("R1 rot", {5'd0, rot_base}, 8'h00);
    chk("R1 flags", {aeoi, nested, raeoi, smask, ierr, drop}, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 pclr", pclr, 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][22:21])
        2'd0: wr(VEC[i][20], VEC[i][19:12]);
        2'd1: begin
          rd(VEC[i][20]);
          chk($sformatf("R%0d table[%0d]", VEC[i][3:0], i), rdata, VEC[i][11:4]);
        end
        2'd2: svc(VEC[i][19:12]);
        default: begin
          @(negedge clk);
          irr = VEC[i][19:12];
        end
      endcase
    end

    chk("R3 vbase", vbase, 8'h40);
    chk("R3 nested", {7'd0, nested}, 8'h01);
    chk("R3 auto_eoi", {7'd0, aeoi}, 8'h01);
    chk("R5 rot_aeoi", {7'd0, raeoi}, 8'h01);
    chk("R4 smask", {7'd0, smask}, 8'h01);
    chk("R8 rot_base", {5'd0, rot_base}, 8'h03);
    chk("R2 err clean", {7'd0, ierr}, 8'h00);

    // R2 start word with unsupported modes, no fourth word
    wr(1'b0, 8'h1A);
    chk("R2 drop pulse", {7'd0, drop}, 8'h01);
    chk("R2 err", {7'd0, ierr}, 8'h01);
    chk("R2 cleared", {smask, raeoi, nested, aeoi, 1'b0, rot_base}, 8'h00);
    @(negedge clk);
    chk("R2 drop ends", {7'd0, drop}, 8'h00);
    wr(1'b1, 8'h88);
    chk("R3 vbase masked", vbase, 8'h88);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h3C);
    chk("R3 skip fourth", mask, 8'h3C);
    chk("R3 modes untouched", {6'd0, nested, aeoi}, 8'h00);
    rd(1'b1);
    chk("R9 mask read", rdata, 8'h3C);

    // R6 empty in-service: code 5 changes nothing
    wr(1'b0, 8'hA0);
    chk("R6 empty rot", {5'd0, rot_base}, 8'h00);
    chk("R6 empty isr", isr, 8'h00);

    // R11 set and specific clear of line 4 in one cycle
    @(negedge clk);
    addr = 1'b0; wdata = 8'h64; wr_en = 1'b1; svc_set = 8'h10;
    @(negedge clk);
    wr_en = 1'b0; svc_set = '0;
    chk("R11 set wins", isr, 8'h10);

    // R10 winning poll: pending line 1 outranks in-service line 4
    @(negedge clk);
    irr = 8'h06;
    wr(1'b0, 8'h0C);
    rd(1'b0);
    chk("R10 poll line", rdata, 8'h01);
    chk("R10 poll clr", pclr, 8'h02);
    chk("R10 isr kept", isr, 8'h10);
    @(negedge clk);
    chk("R10 clr pulse ends", pclr, 8'h00);

    // R11 start word beats set vector
    @(negedge clk);
    addr = 1'b0; wdata = 8'h10; wr_en = 1'b1; svc_set = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0; svc_set = '0;
    chk("R11 init wins", isr, 8'h00);
    chk("R2 err cleared", {7'd0, ierr}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule